// File: doc/BRIEF.md
# Two-Function Add/Multiply Calculator with Hex Display

This block is a small combinational calculator. It reads two 5-bit unsigned operands from two separate groups of slide switches and one push-button that selects the operation. It produces either the sum or the product of the operands. It also drives six seven-segment digits so that both operands and the result are visible together.

Each operand is zero-extended to 8 bits. Both extended operands feed an 8-bit ripple adder and an 8-bit shift-and-add multiplier that keeps only the low byte. A control stage inverts the active-low button and turns it into a pair of select strobes, and a multiplexer uses those strobes to pick the result. Each of the three 8-bit values is split into two hexadecimal nibbles, and each nibble is decoded to an active-low segment pattern. The block holds no state, so every output follows the switches and the button after combinational delay only.

Top module: `calc_display`

## Requirements
- R1: While `opBtnN` is 1 (button released), the result equals (operand 0 + operand 1) modulo 256.
- R2: While `opBtnN` is 0 (button held), the result equals the low 8 bits of operand 0 × operand 1.
- R3: Both operands are zero-extended to 8 bits, so their displayed high digit is always 0 or 1.
- R4: `segOp0` shows operand 0, `segOp1` shows operand 1 and `segRes` shows the result.
- R5: In every 14-bit display port, bits 13:7 hold the high nibble (left digit) and bits 6:0 hold the low nibble (right digit).
- R6: Each digit is active-low with bit 0 = segment a through bit 6 = segment g. The active-high glyphs for 0 to F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71, and all 16 are distinct.
- R7: Product bits above bit 7 are discarded; for example 31 × 31 shows 0xC1.
- R8: 31 + 1 shows 0x20, 16 × 3 shows 0x30 and 16 × 7 shows 0x70.
- R9: There are no storage elements. A change on the button alone changes the result digits with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in0Sw | input | 5 | Operand 0 switches, unsigned |
| in1Sw | input | 5 | Operand 1 switches, unsigned |
| opBtnN | input | 1 | Operation button, active-low (0 = multiply) |
| segOp0 | output | 14 | Two active-low digits showing operand 0 |
| segOp1 | output | 14 | Two active-low digits showing operand 1 |
| segRes | output | 14 | Two active-low digits showing the result |

## Verification
Two functions share the result digits at all times: the sum and the truncated product. The button picks between them, and the operand displays must update together with the result. The bench covers every pair of operands under both button levels. This makes the two arithmetic paths visible through the same digits, and each one is compared with a value the bench works out arithmetically. A further step flips only the button while both operands are held. It confirms that the result switches from sum to product within the same cycle and that the operand digits do not move.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int OPND_W = 5;
  localparam int DATA_W = 8;
  localparam int SEG_W  = 7;
  localparam int NIB_N  = DATA_W / 4;
  localparam int DISP_W = NIB_N * SEG_W;

  typedef struct packed {
    logic selAdd;
    logic selMul;
  } opStrobe_t;
endpackage

// File: rtl/calc_ctrl.sv
module calc_ctrl
  import calc_pkg::*;
(
  input  logic      opBtnN,
  output opStrobe_t strobe
);
  logic pressed;
  // the button pulls its pin low while held
  assign pressed = ~opBtnN;

  always_comb begin
    strobe.selMul = pressed;
    strobe.selAdd = ~pressed;
  end
endmodule

// File: rtl/calc_ripple_add.sv
module calc_ripple_add #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i] = x[i] ^ y[i] ^ carry[i];
    if (i < WIDTH - 1) begin : g_carry
      // the carry out of the top bit is not kept
      assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end
  end
endmodule

// File: rtl/calc_datapath.sv
module calc_datapath
  import calc_pkg::*;
#(
  parameter int IN_W  = OPND_W,
  parameter int OUT_W = DATA_W
) (
  input  logic [IN_W-1:0]  opA,
  input  logic [IN_W-1:0]  opB,
  input  opStrobe_t        strobe,
  output logic [OUT_W-1:0] extA,
  output logic [OUT_W-1:0] extB,
  output logic [OUT_W-1:0] result
);
  localparam int PAD_W = OUT_W - IN_W;

  logic [OUT_W-1:0] sumVal;
  logic [OUT_W-1:0] prodVal;
  logic [OUT_W-1:0] acc [0:OUT_W];

  assign extA = {{PAD_W{1'b0}}, opA};
  assign extB = {{PAD_W{1'b0}}, opB};

  calc_ripple_add #(.WIDTH(OUT_W)) u_sum (
    .x(extA), .y(extB), .sum(sumVal)
  );

  // shift-and-add array; every stage keeps only OUT_W bits
  assign acc[0] = '0;
  for (genvar i = 0; i < OUT_W; i++) begin : g_pp
    logic [OUT_W-1:0] partial;
    assign partial = extB[i] ? (extA << i) : '0;
    calc_ripple_add #(.WIDTH(OUT_W)) u_acc (
      .x(acc[i]), .y(partial), .sum(acc[i+1])
    );
  end
  assign prodVal = acc[OUT_W];

  assign result = ({OUT_W{strobe.selMul}} & prodVal)
                | ({OUT_W{strobe.selAdd}} & sumVal);
endmodule

// File: rtl/calc_hex7.sv
module calc_hex7
  import calc_pkg::*;
(
  input  logic [3:0]       nibble,
  output logic [SEG_W-1:0] segN
);
  logic [SEG_W-1:0] lit;
  always_comb begin
    unique case (nibble)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
  end
  assign segN = ~lit;
endmodule

// File: rtl/calc_display.sv
module calc_display
  import calc_pkg::*;
(
  input  logic [OPND_W-1:0] in0Sw,
  input  logic [OPND_W-1:0] in1Sw,
  input  logic              opBtnN,
  output logic [DISP_W-1:0] segOp0,
  output logic [DISP_W-1:0] segOp1,
  output logic [DISP_W-1:0] segRes
);
  localparam int VAL_N = 3;

  opStrobe_t   strobe;
  logic [DATA_W-1:0] values [VAL_N];
  logic [DISP_W-1:0] disp   [VAL_N];

  calc_ctrl u_ctrl (.opBtnN(opBtnN), .strobe(strobe));

  calc_datapath u_dp (
    .opA(in0Sw), .opB(in1Sw), .strobe(strobe),
    .extA(values[0]), .extB(values[1]), .result(values[2])
  );

  for (genvar v = 0; v < VAL_N; v++) begin : g_val
    for (genvar d = 0; d < NIB_N; d++) begin : g_dig
      calc_hex7 u_dec (
        .nibble(values[v][d*4 +: 4]),
        .segN(disp[v][d*SEG_W +: SEG_W])
      );
    end
  end

  assign segOp0 = disp[0];
  assign segOp1 = disp[1];
  assign segRes = disp[2];
endmodule

// File: rtl/calc_display_chk.sv
module calc_display_chk
  import calc_pkg::*;
(
  input logic [OPND_W-1:0] in0Sw,
  input logic [OPND_W-1:0] in1Sw,
  input logic              opBtnN,
  input logic [DISP_W-1:0] segOp0,
  input logic [DISP_W-1:0] segOp1,
  input logic [DISP_W-1:0] segRes
);
  function automatic logic [13:0] showByte(input logic [7:0] v);
    logic [6:0] g [16];
    g = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
          7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return ~{g[v[7:4]], g[v[3:0]]};
  endfunction

  logic [7:0] a8, b8, sumExp, prodExp;
  logic [15:0] fullProd;
  always_comb begin
    a8 = {3'b000, in0Sw};
    b8 = {3'b000, in1Sw};
    sumExp = a8 + b8;
    fullProd = a8 * b8;
    prodExp = fullProd[7:0];
  end

  always_comb begin
    if (!$isunknown({in0Sw, in1Sw, opBtnN})) begin
      AST_ADD_RESULT: assert (!opBtnN || segRes == showByte(sumExp)); // R1
      AST_MUL_RESULT: assert (opBtnN || segRes == showByte(prodExp)); // R2
      AST_OPND0_HIGH: assert (segOp0[13:7] == ~7'h3F || segOp0[13:7] == ~7'h06); // R3
      AST_OPND1_HIGH: assert (segOp1[13:7] == ~7'h3F || segOp1[13:7] == ~7'h06); // R3
      AST_OPND_SHOWN: assert (segOp0 == showByte(a8) && segOp1 == showByte(b8)); // R4
    end
  end
endmodule

bind calc_display calc_display_chk u_chk (
  .in0Sw(in0Sw), .in1Sw(in1Sw), .opBtnN(opBtnN),
  .segOp0(segOp0), .segOp1(segOp1), .segRes(segRes)
);

// File: tb/sim_calc_display.sv
module sim_calc_display;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  in0Sw, in1Sw;
  logic        opBtnN;
  logic [13:0] segOp0, segOp1, segRes;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  calc_display u0 (
    .in0Sw(in0Sw), .in1Sw(in1Sw), .opBtnN(opBtnN),
    .segOp0(segOp0), .segOp1(segOp1), .segRes(segRes)
  );

  function automatic logic [6:0] glyphOn(input int n);
    case (n)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F; 10: return 7'h77; 11: return 7'h7C;
      12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic logic [13:0] expDisp(input int v);
    return ~{glyphOn((v / 16) % 16), glyphOn(v % 16)};
  endfunction

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s in0=%0d in1=%0d btnN=%0b actual=%h expected=%h",
               tag, in0Sw, in1Sw, opBtnN, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input bit btnN);
    @(posedge clk);
    in0Sw = a[4:0]; in1Sw = b[4:0]; opBtnN = btnN;
    @(negedge clk);
  endtask

  initial begin
    in0Sw = '0; in1Sw = '0; opBtnN = 1'b1;
    @(negedge clk);
    // startup with switches at zero and button released
    check("R1 idle result", segRes, expDisp(0));
    check("R4 idle operand0", segOp0, expDisp(0));

    // exhaustive sweep, both button levels
    for (int btn = 1; btn >= 0; btn--) begin
      for (int a = 0; a < 32; a++) begin
        for (int b = 0; b < 32; b++) begin
          apply(a, b, btn[0]);
          if (btn == 1) check("R1 sum", segRes, expDisp((a + b) % 256));
          else          check("R2 product", segRes, expDisp((a * b) % 256));
          // R3 R5: zero-extended value shown high digit left
          check("R4 R3 R5 operand0", segOp0, expDisp(a));
          check("R4 R3 R5 operand1", segOp1, expDisp(b));
        end
      end
    end

    // R6: every nibble glyph on the low digit of operand 0
    for (int n = 0; n < 16; n++) begin
      apply(n, 0, 1'b1);
      check("R6 glyph", {7'h00, segOp0[6:0]}, {7'h00, ~glyphOn(n)});
    end

    // R7 truncation
    apply(31, 31, 1'b0);
    check("R7 31x31", segRes, ~{7'h39, 7'h06});
    // R8 named cases
    apply(31, 1, 1'b1);
    check("R8 31+1", segRes, ~{7'h5B, 7'h3F});
    apply(16, 3, 1'b0);
    check("R8 16x3", segRes, ~{7'h4F, 7'h3F});
    apply(16, 7, 1'b0);
    check("R8 16x7", segRes, ~{7'h07, 7'h3F});

    // R9: button flips mid-cycle with no clock edge in between
    apply(5, 6, 1'b1);
    check("R9 before", segRes, expDisp(11));
    #1 opBtnN = 1'b0;
    #0.5;
    check("R9 after flip", segRes, expDisp(30));
    check("R9 operand steady", segOp0, expDisp(5));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule